// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits after instruction decode in a two-wide, in-order, single-thread front end. Every cycle the two oldest decoded instructions arrive as a pair of slots: slot 0 holds the older one and slot 1 the younger. Each slot carries a unit class code and three flags: microcoded, non-pipelined and context-synchronizing. The block uses only structural pairing rules to decide whether both slots issue together, whether slot 0 issues alone, or whether nothing issues this cycle. It does not look at opcodes or operand dependencies.

When slot 0 issues alone, the environment moves the old slot 1 instruction into slot 0 on the next cycle. The environment removes from its queue exactly the number of instructions that the issue mask marks as issued. While the stall output is high, the environment holds both slots unchanged.

The control is a three-state machine:

- `ST_RUN` is the normal pairing state.
- `ST_NP_BUBBLE` is a one-cycle dead cycle that follows a non-pipelined instruction issued from slot 0.
- `ST_UC_WAIT` covers the microcode sequencer start-up delay. A down-counter runs in this state and its value is visible on the countdown output.

The transitions are:

- `RUN->NP_BUBBLE` (a non-pipelined instruction issues from slot 0)
- `NP_BUBBLE->RUN` (always, after one cycle)
- `RUN->UC_WAIT` (a microcoded instruction is at slot 0)
- `UC_WAIT->RUN` (the counter reaches zero and the microcoded instruction issues)

In every other case `RUN` stays in `RUN`.

Top module: `dual_issue_pair`

## Requirements
- R1: After reset, whether asynchronous at start-up or in mid-operation, the block is in the run state. With both slots invalid, the issue mask is 0, stall is 0 and the countdown is 0.
- R2: The issue mask has bit 0 for slot 0 and bit 1 for slot 1. It is never 2'b10. With slot 0 invalid nothing issues. With slot 1 invalid, a plain slot 0 instruction issues alone.
- R3: Class codes are fixed-point=0, load/store=1, branch=2, vector arithmetic=3 and vector permute/load-store=4. Two instructions of the same class never pair.
- R4: A load/store instruction never pairs with a vector permute/load-store instruction. Any other pair of distinct valid classes pairs when no flag or slot rule forbids it.
- R5: Class codes 5 to 7 are reserved. An instruction carrying one of them never pairs, in either slot.
- R6: A branch in slot 0 issues alone. A branch in slot 1 may pair with a non-branch instruction in slot 0.
- R7: A non-pipelined instruction in slot 0 issues alone. The following cycle is a bubble with stall=1 and issue mask 0. A non-pipelined instruction in slot 1 does not block pairing.
- R8: A context-synchronizing instruction in either slot prevents pairing, so that slot 0 issues alone.
- R9: A microcoded instruction in slot 1 makes slot 0 issue alone. A microcoded instruction in slot 0 issues only after UC_LAT (default 7) stall cycles with issue mask 0. During those cycles the countdown reads UC_LAT, UC_LAT-1, ..., 1. In the next cycle the instruction issues alone with countdown 0, and no bubble follows even when its non-pipelined flag is also set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_vld_i | input | 1 | Slot 0 holds an instruction |
| s0_cls_i | input | 3 | Slot 0 unit class code |
| s0_ucode_i | input | 1 | Slot 0 is microcoded |
| s0_nonpipe_i | input | 1 | Slot 0 is non-pipelined |
| s0_csync_i | input | 1 | Slot 0 is context-synchronizing |
| s1_vld_i | input | 1 | Slot 1 holds an instruction |
| s1_cls_i | input | 3 | Slot 1 unit class code |
| s1_ucode_i | input | 1 | Slot 1 is microcoded |
| s1_nonpipe_i | input | 1 | Slot 1 is non-pipelined (no effect on pairing) |
| s1_csync_i | input | 1 | Slot 1 is context-synchronizing |
| issue_o | output | 2 | Issue mask, bit 0 = slot 0, bit 1 = slot 1 |
| stall_o | output | 1 | No issue this cycle, slots must be held |
| uc_left_o | output | $clog2(UC_LAT+1) | Remaining microcode stall cycles |

## Verification
Directed pairs walk every class combination, including the reserved codes. This separates same-class conflicts from the load/store versus permute cross conflict and from pairs that are legal. Each flag is then placed alone in slot 0 and alone in slot 1, which tells the slot-specific rules apart: a branch, a non-pipelined or a microcoded instruction behaves differently in each position. Streams with odd lengths and back-to-back microcoded and non-pipelined instructions exercise the re-presentation of slot 1 as the new slot 0, the bubble timing and the countdown sequence. A reset during a microcode wait, followed by a long pseudo-random stream, compares against a queue-based model on every clock.

// File: rtl/dip_pkg.sv
package dip_pkg;

    localparam int CLS_W     = 3;
    localparam int NUM_CLS   = 2 ** CLS_W;
    localparam int USED_CLS  = 5;

    typedef enum logic [CLS_W-1:0] {
        CLS_FX = 3'd0,
        CLS_LS = 3'd1,
        CLS_BR = 3'd2,
        CLS_VA = 3'd3,
        CLS_VP = 3'd4
    } unit_cls_e;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_NP_BUBBLE = 2'd1,
        ST_UC_WAIT   = 2'd2
    } dip_state_e;

    typedef struct packed {
        logic             vld;
        logic [CLS_W-1:0] cls;
        logic             ucode;
        logic             nonpipe;
        logic             csync;
    } slot_t;

    // Structural conflict between two unit classes (symmetric).
    function automatic logic conflict_rule(input int a, input int b);
        if (a >= USED_CLS || b >= USED_CLS) return 1'b1;
        if (a == b) return 1'b1;
        if ((a == int'(CLS_LS) && b == int'(CLS_VP)) ||
            (a == int'(CLS_VP) && b == int'(CLS_LS))) return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/dip_class_conflict.sv
module dip_class_conflict
    import dip_pkg::*;
#(
    parameter int CW = CLS_W
) (
    input  logic [CW-1:0] a_i,
    input  logic [CW-1:0] b_i,
    output logic          hit_o
);

    localparam int NC = 2 ** CW;

    logic [NC*NC-1:0] matrix;

    for (genvar i = 0; i < NC; i++) begin : g_row
        for (genvar j = 0; j < NC; j++) begin : g_col
            assign matrix[i*NC + j] = conflict_rule(i, j);
        end
    end

    assign hit_o = matrix[{a_i, b_i}];

endmodule

// File: rtl/dip_pair_rules.sv
module dip_pair_rules
    import dip_pkg::*;
(
    input  slot_t s0_i,
    input  slot_t s1_i,
    output logic  pair_ok_o,
    output logic  uc_head_o,
    output logic  np_head_o
);

    logic cls_hit;
    logic head_blocks;
    logic tail_blocks;
    logic unused_s1_np;

    dip_class_conflict #(.CW(CLS_W)) u_conflict (
        .a_i   (s0_i.cls),
        .b_i   (s1_i.cls),
        .hit_o (cls_hit)
    );

    // Slot 0 properties that forbid a partner.
    assign head_blocks = s0_i.ucode | s0_i.nonpipe | s0_i.csync |
                         (s0_i.cls == CLS_BR);
    // Slot 1 properties that forbid joining the older instruction.
    assign tail_blocks = s1_i.ucode | s1_i.csync;

    assign pair_ok_o = s0_i.vld & s1_i.vld & ~cls_hit &
                       ~head_blocks & ~tail_blocks;

    assign uc_head_o = s0_i.vld & s0_i.ucode;
    assign np_head_o = s0_i.vld & s0_i.nonpipe & ~s0_i.ucode;

    // A younger non-pipelined instruction has no pairing effect.
    assign unused_s1_np = s1_i.nonpipe;

endmodule

// File: rtl/dip_uc_timer.sv
module dip_uc_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import dip_pkg::*;
#(
    parameter  int UC_LAT = 7,
    localparam int CNT_W  = $clog2(UC_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_vld_i,
    input  logic [2:0]       s0_cls_i,
    input  logic             s0_ucode_i,
    input  logic             s0_nonpipe_i,
    input  logic             s0_csync_i,
    input  logic             s1_vld_i,
    input  logic [2:0]       s1_cls_i,
    input  logic             s1_ucode_i,
    input  logic             s1_nonpipe_i,
    input  logic             s1_csync_i,
    output logic [1:0]       issue_o,
    output logic             stall_o,
    output logic [CNT_W-1:0] uc_left_o
);

    localparam logic [CNT_W-1:0] UC_FIRST = CNT_W'(UC_LAT);
    localparam logic [CNT_W-1:0] UC_LOAD  = CNT_W'(UC_LAT - 1);

    slot_t      s0, s1;
    dip_state_e state_q, state_d;
    logic       pair_ok, uc_head, np_head;
    logic       tmr_load, tmr_dec, tmr_zero;
    logic [CNT_W-1:0] tmr_cnt;

    assign s0 = '{vld: s0_vld_i, cls: s0_cls_i, ucode: s0_ucode_i,
                  nonpipe: s0_nonpipe_i, csync: s0_csync_i};
    assign s1 = '{vld: s1_vld_i, cls: s1_cls_i, ucode: s1_ucode_i,
                  nonpipe: s1_nonpipe_i, csync: s1_csync_i};

    dip_pair_rules u_rules (
        .s0_i      (s0),
        .s1_i      (s1),
        .pair_ok_o (pair_ok),
        .uc_head_o (uc_head),
        .np_head_o (np_head)
    );

    dip_uc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (UC_LOAD),
        .dec_i      (tmr_dec),
        .cnt_o      (tmr_cnt),
        .zero_o     (tmr_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (uc_head) begin
                    state_d = ST_UC_WAIT;
                end else if (np_head) begin
                    state_d = ST_NP_BUBBLE;
                end
            end
            ST_NP_BUBBLE: begin
                state_d = ST_RUN;
            end
            ST_UC_WAIT: begin
                if (tmr_zero) begin
                    state_d = ST_RUN;
                end
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // Outputs
    always_comb begin
        issue_o   = 2'b00;
        stall_o   = 1'b0;
        uc_left_o = '0;
        tmr_load  = 1'b0;
        tmr_dec   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (uc_head) begin
                    stall_o   = 1'b1;
                    uc_left_o = UC_FIRST;
                    tmr_load  = 1'b1;
                end else if (s0.vld) begin
                    issue_o = pair_ok ? 2'b11 : 2'b01;
                end
            end
            ST_NP_BUBBLE: begin
                stall_o = 1'b1;
            end
            ST_UC_WAIT: begin
                if (tmr_zero) begin
                    issue_o = 2'b01;
                end else begin
                    stall_o   = 1'b1;
                    uc_left_o = tmr_cnt;
                    tmr_dec   = 1'b1;
                end
            end
            default: begin
                stall_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s0_vld,
    input logic [2:0]       s0_cls,
    input logic             s0_ucode,
    input logic             s0_nonpipe,
    input logic             s0_csync,
    input logic [2:0]       s1_cls,
    input logic             s1_ucode,
    input logic             s1_csync,
    input logic [1:0]       issue,
    input logic             stall,
    input logic [CNT_W-1:0] uc_left
);

    // R2
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue != 2'b10);

    // R2
    no_head_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s0_vld && !stall && uc_left == '0) |-> issue == 2'b00);

    // R7
    stall_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> issue == 2'b00);

    // R3
    same_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue == 2'b11 |-> s0_cls != s1_cls);

    // R4
    ls_vp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue == 2'b11 |-> !((s0_cls == 3'd1 && s1_cls == 3'd4) ||
                             (s0_cls == 3'd4 && s1_cls == 3'd1)));

    // R5
    reserved_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue == 2'b11 |-> (s0_cls < 3'd5 && s1_cls < 3'd5));

    // R6
    br_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue == 2'b11 |-> s0_cls != 3'd2);

    // R8
    csync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue == 2'b11 |-> !(s0_csync || s1_csync));

    // R9
    ucode_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue == 2'b11 |-> !(s0_ucode || s1_ucode || s0_nonpipe));

    // R9
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uc_left != '0) |=> (uc_left == $past(uc_left) - 1'b1));

    // R7
    np_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue == 2'b01 && s0_nonpipe && !s0_ucode) |=>
            (stall && issue == 2'b00));

endmodule

bind dual_issue_pair dual_issue_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s0_vld     (s0_vld_i),
    .s0_cls     (s0_cls_i),
    .s0_ucode   (s0_ucode_i),
    .s0_nonpipe (s0_nonpipe_i),
    .s0_csync   (s0_csync_i),
    .s1_cls     (s1_cls_i),
    .s1_ucode   (s1_ucode_i),
    .s1_csync   (s1_csync_i),
    .issue      (issue_o),
    .stall      (stall_o),
    .uc_left    (uc_left_o)
);

// File: tb/dual_issue_pair_tb.sv
module dual_issue_pair_tb;

    localparam int UCL = 7;
    localparam int CW  = $clog2(UCL + 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          s0_vld, s0_uc, s0_np, s0_cs;
    logic          s1_vld, s1_uc, s1_np, s1_cs;
    logic [2:0]    s0_cls, s1_cls;
    logic [1:0]    issue;
    logic          stall;
    logic [CW-1:0] uc_left;

    dual_issue_pair #(.UC_LAT(UCL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s0_vld_i(s0_vld), .s0_cls_i(s0_cls), .s0_ucode_i(s0_uc),
        .s0_nonpipe_i(s0_np), .s0_csync_i(s0_cs),
        .s1_vld_i(s1_vld), .s1_cls_i(s1_cls), .s1_ucode_i(s1_uc),
        .s1_nonpipe_i(s1_np), .s1_csync_i(s1_cs),
        .issue_o(issue), .stall_o(stall), .uc_left_o(uc_left)
    );

    typedef struct packed {
        logic [2:0] cls;
        logic       uc;
        logic       np;
        logic       cs;
    } ins_t;

    ins_t q[$];
    int   mode = 0;   // 0 normal, 1 bubble, 2 microcode wait
    int   cnt  = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    int unsigned rng = 32'h1ace_b00c;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int c, input bit uc = 0, input bit np = 0, input bit cs = 0);
        ins_t e;
        e.cls = 3'(c); e.uc = uc; e.np = np; e.cs = cs;
        q.push_back(e);
    endtask

    function automatic bit clash(input int a, input int b);
        if (a > 4 || b > 4) return 1'b1;
        if (a == b) return 1'b1;
        return (a == 1 && b == 4) || (a == 4 && b == 1);
    endfunction

    task automatic drive_idle();
        s0_vld = 0; s0_cls = 0; s0_uc = 0; s0_np = 0; s0_cs = 0;
        s1_vld = 0; s1_cls = 0; s1_uc = 0; s1_np = 0; s1_cs = 0;
    endtask

    task automatic step();
        ins_t  h0, h1;
        bit    v0, v1, single;
        int    em, es, el, npop;
        string tag;
        @(negedge clk);
        v0 = q.size() > 0;
        v1 = q.size() > 1;
        h0 = v0 ? q[0] : '0;
        h1 = v1 ? q[1] : '0;
        s0_vld = v0; s0_cls = h0.cls; s0_uc = h0.uc; s0_np = h0.np; s0_cs = h0.cs;
        s1_vld = v1; s1_cls = h1.cls; s1_uc = h1.uc; s1_np = h1.np; s1_cs = h1.cs;
        #1;
        em = 0; es = 0; el = 0; npop = 0; tag = "R2";
        if (mode == 1) begin
            es = 1; mode = 0; tag = "R7";
        end else if (mode == 2) begin
            tag = "R9";
            if (cnt > 0) begin
                es = 1; el = cnt; cnt--;
            end else begin
                em = 1; npop = 1; mode = 0;
            end
        end else if (!v0) begin
            tag = "R2";
        end else if (h0.uc) begin
            es = 1; el = UCL; cnt = UCL - 1; mode = 2; tag = "R9";
        end else begin
            single = 1;
            if (!v1) tag = "R2";
            else if (h0.cs || h1.cs) tag = "R8";
            else if (h1.uc) tag = "R9";
            else if (h0.np) tag = "R7";
            else if (h0.cls == 3'd2) tag = "R6";
            else if (h0.cls > 3'd4 || h1.cls > 3'd4) tag = "R5";
            else if (h0.cls == h1.cls) tag = "R3";
            else if (clash(int'(h0.cls), int'(h1.cls))) tag = "R4";
            else begin
                single = 0;
                tag = (h1.cls == 3'd2) ? "R6" : (h1.np ? "R7" : "R4");
            end
            em   = single ? 1 : 3;
            npop = single ? 1 : 2;
            if (h0.np) mode = 1;
        end
        chk(tag, "issue", int'(issue), em);
        chk(tag, "stall", int'(stall), es);
        chk(tag, "uc_left", int'(uc_left), el);
        for (int k = 0; k < npop; k++) void'(q.pop_front());
    endtask

    task automatic drain();
        int guard = 0;
        while ((q.size() > 0 || mode != 0) && guard < 5000) begin
            step();
            guard++;
        end
        repeat (2) step();
    endtask

    function automatic int unsigned nxt();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    initial begin
        int unsigned r;
        int c;
        drive_idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1", "issue", int'(issue), 0);
        chk("R1", "stall", int'(stall), 0);
        chk("R1", "uc_left", int'(uc_left), 0);
        @(negedge clk);
        rst_n = 1;

        // R3 same class pairs
        for (int k = 0; k < 5; k++) begin push(k); push(k); end
        drain();
        // R4 all distinct valid class pairs, both orders
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                if (a != b && a != 2) begin push(a); push(b); end
        drain();
        // R5 reserved codes in each slot
        for (int k = 5; k < 8; k++) begin push(0); push(k); push(k); push(3); end
        drain();
        // R6 branch in slot 0 and in slot 1
        push(2); push(0); push(0); push(2); push(2); push(2);
        drain();
        // R7 non-pipelined in slot 0, in slot 1, back to back
        push(0, 0, 1); push(1); push(3); push(4, 0, 1);
        push(0, 0, 1); push(0, 0, 1); push(3);
        drain();
        // R8 context-synchronizing in each slot
        push(0, 0, 0, 1); push(1); push(3); push(4, 0, 0, 1); push(0); push(1);
        drain();
        // R9 microcode in slot 1, in slot 0, with non-pipelined flag, back to back
        push(0); push(1, 1); push(3);
        push(0, 1, 1); push(1); push(0, 1); push(0, 1);
        drain();
        // R2 odd-length stream, slot 1 empty at the tail
        push(0); push(1); push(3);
        drain();

        // R1 reset during a microcode wait
        push(0, 1); push(1);
        repeat (3) step();
        @(negedge clk);
        rst_n = 0;
        drive_idle();
        q.delete(); mode = 0; cnt = 0;
        #1;
        chk("R1", "stall", int'(stall), 0);
        chk("R1", "uc_left", int'(uc_left), 0);
        chk("R1", "issue", int'(issue), 0);
        @(negedge clk);
        rst_n = 1;
        drain();

        // Mixed pseudo-random stream
        for (int n = 0; n < 600; n++) begin
            r = nxt();
            c = int'(r % 10);
            if (c > 7) c = int'((r >> 4) % 5);
            push(c, (r[12:9] == 4'd0), (r[16:14] == 3'd0), (r[20:18] == 3'd0));
        end
        drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule